// File: doc/BRIEF.md
# USB Status LED Controller

This block turns the link status of a USB storage bridge into the signals that light its indicator LEDs. It watches whether the host link is up, whether it runs at SuperSpeed or at USB 2.0 speed, whether the link is suspended, and which USB3 power state (U0 to U3) the link reports. From these inputs it drives a pulse-width modulated activity LED, a pulse-width modulated heartbeat LED, and a pair of general-purpose lines that show the link power state.

The activity LED stays lit while a link exists and is dark without one. Every pulse on the activity strobe starts a blink window of 100 ms. During that window the LED blinks at 10 Hz on a USB 2.0 link and at 20 Hz on a SuperSpeed link. While the link is suspended or in U3, the LED breathes on a triangular ramp with a 2 s period. Both LED outputs are active-low, so a pin duty of 0 % means the LED is fully lit. The two state lines are driven only when low-power link states are enabled. Otherwise they are released.

All timing comes from the `CLK_HZ` and `PWM_HZ` parameters. The carrier has 256 steps and runs at `CLK_HZ / (256 * max(1, CLK_HZ / (256 * PWM_HZ)))`.

Top module: `usb_led_ctrl`

## Requirements
- R1: While `usb_connected` is low, `act_led_pwm` stays high (dark) and pulses on `act_strobe` have no effect.
- R2: While connected, with no blink window open and no suspend, `act_led_pwm` stays low (fully lit).
- R3: On a USB 2.0 link (`link_ss` = 0), a strobe opens a blink window whose phases each last `CLK_HZ/20` cycles (10 Hz). The first phase is dark.
- R4: On a SuperSpeed link (`link_ss` = 1), the blink phases each last `CLK_HZ/40` cycles (20 Hz). The first phase is dark.
- R5: The blink window stays open for `CLK_HZ/10` cycles after the most recent strobe. A new strobe restarts that span without resetting the blink phase.
- R6: When `hs_suspend` is high, or when `u_valid` is high with `u_state` = 3, the activity LED fades. Its brightness level moves 0→255→0 by one step every `CLK_HZ/255` cycles, and the LED is low for level+1 of every 256 carrier steps.
- R7: Blinking takes priority over fading, and fading takes priority over steady lit.
- R8: `hb_led_pwm` is a square wave with half-period `CLK_HZ/2` cycles (1 Hz). It starts in its lit (low) half after reset.
- R9: Each LED pin is high for `duty` of every 256 carrier steps, so duty 0 means the pin is constantly low (fully lit).
- R10: With `lpm_en` high, one cycle after the inputs `lnk_pin` = `u_state` when `u_valid` is high, and 2'b00 when it is low. `lnk_pin[0]` is the first line and `lnk_pin[1]` the second, so U0→00, U1→01, U2→10, U3→11.
- R11: `lnk_oe` follows `lpm_en` one cycle later. While `lpm_en` is low, `lnk_pin` reads 2'b00.
- R12: During reset, `act_led_pwm` and `hb_led_pwm` are high, and `lnk_pin` and `lnk_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_connected | input | 1 | Host link is up |
| act_strobe | input | 1 | One-cycle pulse per disk activity event |
| link_ss | input | 1 | 1 = SuperSpeed link, 0 = USB 2.0 link |
| hs_suspend | input | 1 | USB 2.0 link is suspended |
| u_state | input | 2 | USB3 link power state, 0..3 = U0..U3 |
| u_valid | input | 1 | `u_state` holds a defined state |
| lpm_en | input | 1 | U1/U2 low-power states are enabled |
| act_led_pwm | output | 1 | Activity LED, active-low PWM |
| hb_led_pwm | output | 1 | Heartbeat LED, active-low PWM |
| lnk_pin | output | 2 | Link power-state code lines |
| lnk_oe | output | 1 | Drive enable for `lnk_pin` |

## Verification
The bench builds the block with `CLK_HZ` = 25600 and `PWM_HZ` = 100. This gives a one-cycle prescaler, a 256-cycle carrier, blink phases of 1280 and 640 cycles, a blink window of 2560 cycles, fade steps of 100 cycles and a heartbeat half-period of 12800 cycles. At these values the bench can watch a full 2 s fade triangle, both blink rates and a retriggered blink window, and whole heartbeat periods. Low-sample counts over single carrier periods show the duty mapping at the fade extremes and at its midpoint.

// File: rtl/usb_led_pkg.sv
// Package: shared constants and types for the USB status LED controller.
// Assumes an 8-bit PWM carrier for every LED channel.
package usb_led_pkg;
    localparam int LED_DUTY_W = 8;
    localparam int LED_NCH    = 2;
    localparam int CH_ACT     = 0;
    localparam int CH_HB      = 1;

    typedef logic [LED_DUTY_W-1:0] duty_t;

    // Source currently steering the activity LED, highest priority first after OFF
    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_BLINK  = 2'd1,
        SRC_FADE   = 2'd2,
        SRC_STEADY = 2'd3
    } act_src_e;
endpackage

// File: rtl/led_pwm_gen.sv
// Module: shared-carrier PWM for NCH active-low LED channels.
// Each channel pin is high while carrier < duty, or always when force_dark is set.
// Assumes PRESC >= 1; the carrier advances one step every PRESC cycles.
module led_pwm_gen
    import usb_led_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int PRESC = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  duty_t [NCH-1:0]      duty,
    input  logic  [NCH-1:0]      force_dark,
    output logic  [NCH-1:0]      pin_n
);
    duty_t carrier;
    logic  step;

    generate
        if (PRESC > 1) begin : g_presc
            localparam int PW = $clog2(PRESC);
            localparam logic [PW-1:0] PLIM = PW'(PRESC - 1);
            logic [PW-1:0] pcnt;
            // Prescaler: emit one step pulse every PRESC cycles
            always_ff @(posedge clk) begin
                if (!rst_n || pcnt == PLIM) pcnt <= '0;
                else                        pcnt <= pcnt + 1'b1;
            end
            assign step = (pcnt == PLIM);
        end else begin : g_nopresc
            assign step = 1'b1;
        end
    endgenerate

    // Carrier: free-running 8-bit ramp, wraps every 256 steps
    always_ff @(posedge clk) begin
        if (!rst_n)    carrier <= '0;
        else if (step) carrier <= carrier + 1'b1;
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic q;
            // Channel compare: register the pin, dark during reset
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b1;
                else        q <= force_dark[i] | (carrier < duty[i]);
            end
            assign pin_n[i] = q;
        end
    endgenerate
endmodule

// File: rtl/led_act_timer.sv
// Module: activity blink window and blink phase generator.
// A strobe (while enabled) reloads the hold span; while the span is open the
// lit flag toggles every HS_HALF or SS_HALF cycles, starting dark.
// Assumes HS_HALF >= SS_HALF >= 1 and HOLD_CYC >= 1.
module led_act_timer #(
    parameter int HOLD_CYC = 10,
    parameter int HS_HALF  = 4,
    parameter int SS_HALF  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic ss,
    output logic blink_on,
    output logic blink_lit
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam int HALF_W = $clog2(HS_HALF + 1);
    localparam logic [HOLD_W-1:0] HOLD_V = HOLD_W'(HOLD_CYC);
    localparam logic [HALF_W-1:0] HS_LIM = HALF_W'(HS_HALF - 1);
    localparam logic [HALF_W-1:0] SS_LIM = HALF_W'(SS_HALF - 1);

    logic [HOLD_W-1:0] hold;
    logic [HALF_W-1:0] half;
    logic [HALF_W-1:0] lim;

    assign blink_on = (hold != '0);
    assign lim      = ss ? SS_LIM : HS_LIM;

    // Hold span: reload on strobe, count down to zero, clear when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en)    hold <= '0;
        else if (strobe)      hold <= HOLD_V;
        else if (hold != '0)  hold <= hold - 1'b1;
    end

    // Blink phase: toggle at the end of each half period while the span is open
    always_ff @(posedge clk) begin
        if (!rst_n || !blink_on) begin
            half      <= '0;
            blink_lit <= 1'b0;
        end else if (half >= lim) begin
            half      <= '0;
            blink_lit <= ~blink_lit;
        end else begin
            half      <= half + 1'b1;
        end
    end
endmodule

// File: rtl/led_fade_gen.sv
// Module: triangular brightness ramp for the suspend breathing effect.
// While enabled the level climbs 0..255 and falls back to 0, one step every
// STEP_CYC cycles; disabling returns it to 0 on a rising slope.
module led_fade_gen
    import usb_led_pkg::*;
#(
    parameter int STEP_CYC = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    output duty_t level
);
    localparam int SW = $clog2(STEP_CYC + 1);
    localparam logic [SW-1:0] SLIM = SW'(STEP_CYC - 1);

    logic [SW-1:0] scnt;
    logic          rising;

    // Step timer and ramp: advance the level one unit per step tick
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            scnt   <= '0;
            level  <= '0;
            rising <= 1'b1;
        end else if (scnt == SLIM) begin
            scnt <= '0;
            if (rising) begin
                if (level == '1) begin
                    rising <= 1'b0;
                    level  <= level - 1'b1;
                end else begin
                    level <= level + 1'b1;
                end
            end else begin
                if (level == '0) begin
                    rising <= 1'b1;
                    level  <= level + 1'b1;
                end else begin
                    level <= level - 1'b1;
                end
            end
        end else begin
            scnt <= scnt + 1'b1;
        end
    end
endmodule

// File: rtl/led_hbeat.sv
// Module: square-wave heartbeat, lit for HALF_CYC cycles then dark for HALF_CYC.
// Starts in the lit half after reset.
module led_hbeat #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic lit
);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam logic [HW-1:0] HLIM = HW'(HALF_CYC - 1);

    logic [HW-1:0] cnt;

    // Half-period counter: flip the lit flag at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lit <= 1'b1;
        end else if (cnt == HLIM) begin
            cnt <= '0;
            lit <= ~lit;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/usb_led_ctrl.sv
// Module: USB status LED controller top.
// Picks the activity LED source by priority (off > blink > fade > steady),
// maps it to an active-low PWM duty, runs the heartbeat channel and registers
// the link power-state code lines. Assumes all inputs are synchronous to clk.
module usb_led_ctrl
    import usb_led_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int PWM_HZ = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       usb_connected,
    input  logic       act_strobe,
    input  logic       link_ss,
    input  logic       hs_suspend,
    input  logic [1:0] u_state,
    input  logic       u_valid,
    input  logic       lpm_en,
    output logic       act_led_pwm,
    output logic       hb_led_pwm,
    output logic [1:0] lnk_pin,
    output logic       lnk_oe
);
    localparam int PRESC_RAW = CLK_HZ / (PWM_HZ * 256);
    localparam int PRESC     = (PRESC_RAW < 1) ? 1 : PRESC_RAW;
    localparam int HS_HALF   = CLK_HZ / 20;
    localparam int SS_HALF   = CLK_HZ / 40;
    localparam int HOLD_CYC  = CLK_HZ / 10;
    localparam int FSTEP_RAW = CLK_HZ / 255;
    localparam int FADE_STEP = (FSTEP_RAW < 1) ? 1 : FSTEP_RAW;
    localparam int HB_HALF   = CLK_HZ / 2;

    logic     blink_on, blink_lit, fade_en, hb_lit, in_susp;
    duty_t    fade_lvl;
    act_src_e act_src;
    duty_t [LED_NCH-1:0] ch_duty;
    logic  [LED_NCH-1:0] ch_force;
    logic  [LED_NCH-1:0] ch_pin;

    led_act_timer #(
        .HOLD_CYC (HOLD_CYC),
        .HS_HALF  (HS_HALF),
        .SS_HALF  (SS_HALF)
    ) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (usb_connected),
        .strobe    (act_strobe),
        .ss        (link_ss),
        .blink_on  (blink_on),
        .blink_lit (blink_lit)
    );

    assign in_susp = hs_suspend | (u_valid & (u_state == 2'd3));
    assign fade_en = usb_connected & in_susp & ~blink_on;

    led_fade_gen #(
        .STEP_CYC (FADE_STEP)
    ) u_fade (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fade_en),
        .level (fade_lvl)
    );

    led_hbeat #(
        .HALF_CYC (HB_HALF)
    ) u_hb (
        .clk   (clk),
        .rst_n (rst_n),
        .lit   (hb_lit)
    );

    // Source priority for the activity LED
    always_comb begin
        if (!usb_connected) act_src = SRC_OFF;
        else if (blink_on)  act_src = SRC_BLINK;
        else if (fade_en)   act_src = SRC_FADE;
        else                act_src = SRC_STEADY;
    end

    // Duty mapping: pin-high fraction is the dark fraction (active-low LEDs)
    always_comb begin
        ch_duty[CH_ACT]  = '0;
        ch_force[CH_ACT] = 1'b0;
        unique case (act_src)
            SRC_OFF:    ch_force[CH_ACT] = 1'b1;
            SRC_BLINK:  ch_force[CH_ACT] = ~blink_lit;
            SRC_FADE:   ch_duty[CH_ACT]  = ~fade_lvl;
            SRC_STEADY: ch_duty[CH_ACT]  = '0;
            default:    ch_force[CH_ACT] = 1'b1;
        endcase
        ch_duty[CH_HB]  = '0;
        ch_force[CH_HB] = ~hb_lit;
    end

    led_pwm_gen #(
        .NCH   (LED_NCH),
        .PRESC (PRESC)
    ) u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty       (ch_duty),
        .force_dark (ch_force),
        .pin_n      (ch_pin)
    );

    assign act_led_pwm = ch_pin[CH_ACT];
    assign hb_led_pwm  = ch_pin[CH_HB];

    // Link power-state lines: code driven only with low-power states enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lnk_pin <= 2'b00;
            lnk_oe  <= 1'b0;
        end else begin
            lnk_oe  <= lpm_en;
            lnk_pin <= (lpm_en && u_valid) ? u_state : 2'b00;
        end
    end
endmodule

// File: rtl/usb_led_ctrl_chk.sv
// Checker: temporal properties of the USB status LED controller, bound to the top.
module usb_led_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       usb_connected,
    input logic       act_strobe,
    input logic [1:0] u_state,
    input logic       u_valid,
    input logic       lpm_en,
    input logic       act_led_pwm,
    input logic [1:0] lnk_pin,
    input logic       lnk_oe,
    input logic       blink_on,
    input logic       blink_lit,
    input logic       fade_en
);
    // R1
    unplugged_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_connected |=> act_led_pwm);
    // R2
    steady_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_connected && !blink_on && !fade_en) |=> !act_led_pwm);
    // R5
    strobe_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_connected && act_strobe) |=> blink_on);
    // R7
    blink_over_fade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_connected && blink_on && !blink_lit) |=> act_led_pwm);
    // R10
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_en && u_valid) |=> (lnk_pin == $past(u_state)));
    // R10
    invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !u_valid |=> (lnk_pin == 2'b00));
    // R11
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lpm_en |=> (!lnk_oe && lnk_pin == 2'b00));
    // R11
    driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_en |=> lnk_oe);
endmodule

bind usb_led_ctrl usb_led_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .usb_connected (usb_connected),
    .act_strobe    (act_strobe),
    .u_state       (u_state),
    .u_valid       (u_valid),
    .lpm_en        (lpm_en),
    .act_led_pwm   (act_led_pwm),
    .lnk_pin       (lnk_pin),
    .lnk_oe        (lnk_oe),
    .blink_on      (blink_on),
    .blink_lit     (blink_lit),
    .fade_en       (fade_en)
);

// File: tb/usb_led_ctrl_tb.sv
// Bench: directed LED timing scenarios plus seeded random state-line vectors.
module usb_led_ctrl_tb;
    localparam int B_CLK  = 25600;
    localparam int B_PWM  = 100;
    localparam int HS_H   = B_CLK / 20;
    localparam int SS_H   = B_CLK / 40;
    localparam int FSTEP  = B_CLK / 255;
    localparam int HB_H   = B_CLK / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_connected = 1'b0, act_strobe = 1'b0, link_ss = 1'b0;
    logic       hs_suspend = 1'b0, u_valid = 1'b0, lpm_en = 1'b0;
    logic [1:0] u_state = 2'b00;
    logic       act_led_pwm, hb_led_pwm, lnk_oe;
    logic [1:0] lnk_pin;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_led_ctrl #(.CLK_HZ(B_CLK), .PWM_HZ(B_PWM)) u_dut (
        .clk(clk), .rst_n(rst_n), .usb_connected(usb_connected),
        .act_strobe(act_strobe), .link_ss(link_ss), .hs_suspend(hs_suspend),
        .u_state(u_state), .u_valid(u_valid), .lpm_en(lpm_en),
        .act_led_pwm(act_led_pwm), .hb_led_pwm(hb_led_pwm),
        .lnk_pin(lnk_pin), .lnk_oe(lnk_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        act_strobe = 1'b1;
        @(negedge clk);
        act_strobe = 1'b0;
    endtask

    task automatic count_low(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (!act_led_pwm) c++;
        end
    endtask

    // Expected low samples per carrier period for the fade at elapsed cycles
    function automatic int fade_lows(input int cyc);
        int m;
        m = (cyc / FSTEP) % 510;
        return ((m <= 255) ? m : 510 - m) + 1;
    endfunction

    function automatic logic [2:0] exp_lines(input logic v, input logic [1:0] u, input logic en);
        return en ? {1'b1, (v ? u : 2'b00)} : 3'b000;
    endfunction

    task automatic act_is(input logic exp, input string req);
        chk(act_led_pwm === exp, req, int'(act_led_pwm), int'(exp));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    // Heartbeat checks, timed from reset release (R8)
    initial begin
        wait (rst_n === 1'b1);
        step(HB_H / 2);
        chk(hb_led_pwm === 1'b0, "R8 lit half", int'(hb_led_pwm), 0);
        step(HB_H);
        chk(hb_led_pwm === 1'b1, "R8 dark half", int'(hb_led_pwm), 1);
        step(HB_H);
        chk(hb_led_pwm === 1'b0, "R8 second period", int'(hb_led_pwm), 0);
    end

    initial begin
        int c;
        int unsigned seed;
        seed = $urandom(32'd4711);
        // R12 reset state
        step(5);
        chk(act_led_pwm === 1'b1 && hb_led_pwm === 1'b1, "R12 led pins", int'({act_led_pwm, hb_led_pwm}), 3);
        chk(lnk_pin === 2'b00 && lnk_oe === 1'b0, "R12 lines", int'({lnk_oe, lnk_pin}), 0);
        rst_n = 1'b1;

        // R1 unplugged: dark, strobe ignored
        step(10);
        strobe();
        count_low(2000, c);
        chk(c == 0, "R1 unplugged dark", c, 0);

        // R2 steady lit
        usb_connected = 1'b1;
        step(10);
        count_low(300, c);
        chk(c == 300, "R2 steady lit", c, 300);

        // R3 USB 2.0 blink
        link_ss = 1'b0;
        strobe();
        step(HS_H / 2);          act_is(1'b1, "R3 first phase dark");
        step(HS_H);              act_is(1'b0, "R3 second phase lit");
        step(HS_H * 2 - 1280 + 840 - 1280 + 1280 - 1280 + 0 + 0); // to t0+2760
        act_is(1'b0, "R5 window closed, steady");

        // R4 SuperSpeed blink and R5 retrigger
        link_ss = 1'b1;
        step(20);
        strobe();
        step(SS_H / 2);          act_is(1'b1, "R4 first phase dark");
        step(SS_H);              act_is(1'b0, "R4 second phase lit");
        step(SS_H);              act_is(1'b1, "R4 third phase dark");
        step(800);               // t0+2400.5
        strobe();                // retrigger at t0+2401
        step(360);               // t0+2761.5, fifth phase (dark)
        act_is(1'b1, "R5 retrigger keeps blinking");
        step(3000);
        act_is(1'b0, "R5 retriggered window closed");

        // R6 fade on USB 2.0 suspend, full triangle, R9 duty mapping
        link_ss = 1'b0;
        hs_suspend = 1'b1;
        count_low(256, c);
        chk(c <= fade_lows(128) + 6 && c + 6 >= fade_lows(128), "R6/R9 fade start", c, fade_lows(128));
        step(25372 - 256);
        count_low(256, c);
        chk(c + 6 >= fade_lows(25500), "R6/R9 fade peak", c, fade_lows(25500));
        step(50872 - 25628);
        count_low(256, c);
        chk(c <= fade_lows(51000) + 6, "R6/R9 fade back to dark", c, fade_lows(51000));

        // Leave suspend: steady again (R2)
        hs_suspend = 1'b0;
        step(300);
        count_low(256, c);
        chk(c == 256, "R2 steady after suspend", c, 256);

        // R6 fade from U3
        u_state = 2'd3;
        u_valid = 1'b1;
        step(12672);
        count_low(256, c);
        chk(c <= fade_lows(12800) + 6 && c + 6 >= fade_lows(12800), "R6 U3 fade mid", c, fade_lows(12800));

        // R7 blink overrides fade
        strobe();
        step(100);
        count_low(256, c);
        chk(c == 0, "R7 blink dark over fade", c, 0);
        step(1000);
        count_low(256, c);
        chk(c == 256, "R7 blink lit over fade", c, 256);
        u_valid = 1'b0;
        step(3000);

        // R10/R11 directed corners
        lpm_en = 1'b1;
        u_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            u_state = 2'(k);
            step(1);
            chk({lnk_oe, lnk_pin} === exp_lines(1'b1, 2'(k), 1'b1), "R10 code per state",
                int'({lnk_oe, lnk_pin}), int'(exp_lines(1'b1, 2'(k), 1'b1)));
        end
        u_valid = 1'b0;
        step(1);
        chk({lnk_oe, lnk_pin} === 3'b100, "R10 invalid state", int'({lnk_oe, lnk_pin}), 4);
        u_valid = 1'b1;
        lpm_en = 1'b0;
        step(1);
        chk({lnk_oe, lnk_pin} === 3'b000, "R11 released", int'({lnk_oe, lnk_pin}), 0);

        // R10/R11 random vectors
        for (int k = 0; k < 200; k++) begin
            logic [2:0] r;
            r = 3'($urandom);
            u_state = 2'($urandom);
            u_valid = r[0];
            lpm_en  = r[1];
            step(1);
            chk({lnk_oe, lnk_pin} === exp_lines(u_valid, u_state, lpm_en), "R10/R11 random",
                int'({lnk_oe, lnk_pin}), int'(exp_lines(u_valid, u_state, lpm_en)));
        end

        summary();
    end
endmodule